// File: doc/BRIEF.md
# Bitfield Parameter Decoder

This block prepares the control values that a bitfield datapath consumes for one instruction. The field width comes either from an immediate in the extension word or from a register value, selected by a flag in that word. The field offset arrives as a full 32-bit value. The block derives the following from these inputs:

- the width minus one;
- the offset inside the long word;
- the combined bit-hit count;
- the complementary shift amount;
- an odd flag;
- how many memory bytes the field covers.

A memory target is read with byte precision, so for a memory target only the offset's position inside a byte matters. The shift amounts are reduced to that range.

All results are captured in one register stage when a load strobe is high. They hold until the next strobe. The full offset is passed through unchanged, because the find-first-one operation needs the true offset to build its result.

Top module: `bfp_decoder`

## Requirements
- R1: `widthM1` loads as `(regWidthVal - 1) mod 32` when `extWidthSel` is 1. Otherwise it loads as `(extWidthImm - 1) mod 32`. A source value of 0 therefore yields 31, which stands for a width of 32.
- R2: For a register target (`targetMode` == 2'b00), `lowOffset` loads `offsetIn[4:0]`.
- R3: `hitCount` loads the 6-bit sum of the zero-extended width-minus-one and the zero-extended low offset, as reported on `widthM1` and `lowOffset`.
- R4: For a register target, `shiftLow` loads `31 - hitCount[4:0]`.
- R5: For a memory target (`targetMode` != 2'b00), `lowOffset` loads `offsetIn[2:0]` with bits 4:3 equal to 0. The hit count is formed from that reduced offset. `shiftLow` loads `7 - hitCount[2:0]`, with bits 4:3 equal to 0.
- R6: `oddFlag` loads the inverse of bit 3 of the new hit count.
- R7: `byteSpan` loads `hitCount[5:3] + 1` for a memory target, giving 1 to 5 bytes. It loads 0 for a register target.
- R8: `fullOffset` loads `offsetIn` unchanged.
- R9: While `loadStb` is low, every output holds its value whatever the other inputs do.
- R10: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Capture strobe for all results |
| extWidthSel | input | 1 | 1: width from register value, 0: width from immediate |
| extWidthImm | input | 5 | Immediate width field of the extension word |
| regWidthVal | input | 5 | Low bits of the register that holds the width |
| targetMode | input | 2 | Addressing-mode bits; 2'b00 means register target |
| offsetIn | input | 32 | Full bitfield offset |
| widthM1 | output | 5 | Width minus one |
| lowOffset | output | 5 | Offset inside the long word (byte-reduced for memory) |
| shiftLow | output | 5 | Complementary shift amount |
| hitCount | output | 6 | Width-minus-one plus low offset |
| oddFlag | output | 1 | Inverse of hit count bit 3 |
| byteSpan | output | 3 | Bytes covered by a memory field, 0 for register |
| fullOffset | output | 32 | Offset passed through unchanged |

## Verification
The bench builds the block with its default parameters: a 32-bit offset and a 5-bit width field. These defaults reach every byte span from one to five and the largest register hit count of 62. The vectors cover the following cases:

- Width 32, encoded as zero, from both width sources.
- Offsets whose high bits must be dropped for memory targets.
- All three memory encodings of the mode bits.
- Stretches with the strobe low while every input changes.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef struct packed {
    logic capture;
    logic memTarget;
    logic widthFromReg;
  } bfpStrobes_t;
endpackage

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
  import bfp_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              loadStb,
  input  logic              extWidthSel,
  input  logic [MODE_W-1:0] targetMode,
  output bfpStrobes_t       strobes
);
  always_comb begin
    strobes.capture      = loadStb;
    strobes.memTarget    = |targetMode;
    strobes.widthFromReg = extWidthSel;
  end
endmodule

// File: rtl/bfp_datapath.sv
module bfp_datapath
  import bfp_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int LOG2W  = 5,
  parameter int SPAN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfpStrobes_t      strobes,
  input  logic [LOG2W-1:0] extWidthImm,
  input  logic [LOG2W-1:0] regWidthVal,
  input  logic [OFF_W-1:0] offsetIn,
  output logic [LOG2W-1:0] widthM1,
  output logic [LOG2W-1:0] lowOffset,
  output logic [LOG2W-1:0] shiftLow,
  output logic [LOG2W:0]   hitCount,
  output logic             oddFlag,
  output logic [SPAN_W-1:0] byteSpan,
  output logic [OFF_W-1:0] fullOffset
);
  localparam int HIT_W = LOG2W + 1;
  localparam logic [LOG2W-1:0] ALL_ONES  = {LOG2W{1'b1}};
  localparam logic [LOG2W-1:0] BYTE_MASK = LOG2W'(7);

  logic [LOG2W-1:0] widthSrc, widthNext, lowOffNext, shiftNext;
  logic [HIT_W-1:0] hitNext;
  logic [SPAN_W-1:0] spanNext;

  always_comb begin
    widthSrc  = strobes.widthFromReg ? regWidthVal : extWidthImm;
    widthNext = widthSrc - LOG2W'(1);
    lowOffNext = offsetIn[LOG2W-1:0];
    if (strobes.memTarget) lowOffNext = lowOffNext & BYTE_MASK;
    hitNext = {1'b0, widthNext} + {1'b0, lowOffNext};
    shiftNext = ALL_ONES - hitNext[LOG2W-1:0];
    if (strobes.memTarget) shiftNext = shiftNext & BYTE_MASK;
    if (strobes.memTarget)
      spanNext = SPAN_W'(hitNext[HIT_W-1:3]) + SPAN_W'(1);
    else
      spanNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthM1    <= '0;
      lowOffset  <= '0;
      shiftLow   <= '0;
      hitCount   <= '0;
      oddFlag    <= 1'b0;
      byteSpan   <= '0;
      fullOffset <= '0;
    end else if (strobes.capture) begin
      widthM1    <= widthNext;
      lowOffset  <= lowOffNext;
      shiftLow   <= shiftNext;
      hitCount   <= hitNext;
      oddFlag    <= ~hitNext[3];
      byteSpan   <= spanNext;
      fullOffset <= offsetIn;
    end
  end
endmodule

// File: rtl/bfp_decoder.sv
module bfp_decoder
  import bfp_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int LOG2W  = 5,
  parameter int MODE_W = 2,
  parameter int SPAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              extWidthSel,
  input  logic [LOG2W-1:0]  extWidthImm,
  input  logic [LOG2W-1:0]  regWidthVal,
  input  logic [MODE_W-1:0] targetMode,
  input  logic [OFF_W-1:0]  offsetIn,
  output logic [LOG2W-1:0]  widthM1,
  output logic [LOG2W-1:0]  lowOffset,
  output logic [LOG2W-1:0]  shiftLow,
  output logic [LOG2W:0]    hitCount,
  output logic              oddFlag,
  output logic [SPAN_W-1:0] byteSpan,
  output logic [OFF_W-1:0]  fullOffset
);
  bfpStrobes_t strobes;

  bfp_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .loadStb(loadStb), .extWidthSel(extWidthSel),
    .targetMode(targetMode), .strobes(strobes)
  );

  bfp_datapath #(.OFF_W(OFF_W), .LOG2W(LOG2W), .SPAN_W(SPAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .extWidthImm(extWidthImm), .regWidthVal(regWidthVal), .offsetIn(offsetIn),
    .widthM1(widthM1), .lowOffset(lowOffset), .shiftLow(shiftLow),
    .hitCount(hitCount), .oddFlag(oddFlag), .byteSpan(byteSpan),
    .fullOffset(fullOffset)
  );
endmodule

// File: rtl/bfp_decoder_chk.sv
module bfp_decoder_chk #(
  parameter int OFF_W  = 32,
  parameter int LOG2W  = 5,
  parameter int MODE_W = 2,
  parameter int SPAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic              extWidthSel,
  input logic [LOG2W-1:0]  extWidthImm,
  input logic [LOG2W-1:0]  regWidthVal,
  input logic [MODE_W-1:0] targetMode,
  input logic [OFF_W-1:0]  offsetIn,
  input logic [LOG2W-1:0]  widthM1,
  input logic [LOG2W-1:0]  lowOffset,
  input logic [LOG2W-1:0]  shiftLow,
  input logic [LOG2W:0]    hitCount,
  input logic              oddFlag,
  input logic [SPAN_W-1:0] byteSpan,
  input logic [OFF_W-1:0]  fullOffset
);
  logic loaded;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loaded <= 1'b0;
    else if (loadStb) loaded <= 1'b1;
  end

  AST_WIDTH_IMM: assert property (@(posedge clk) disable iff (!rstN)
    loadStb && !extWidthSel |=> widthM1 == LOG2W'($past(extWidthImm) - LOG2W'(1))); // R1
  AST_WIDTH_REG: assert property (@(posedge clk) disable iff (!rstN)
    loadStb && extWidthSel |=> widthM1 == LOG2W'($past(regWidthVal) - LOG2W'(1))); // R1
  AST_SHIFT_REG: assert property (@(posedge clk) disable iff (!rstN)
    loaded && byteSpan == '0 |-> LOG2W'(shiftLow + hitCount[LOG2W-1:0]) == {LOG2W{1'b1}}); // R4
  AST_MEM_BYTE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    byteSpan != '0 |-> lowOffset[LOG2W-1:3] == '0 && shiftLow[LOG2W-1:3] == '0); // R5
  AST_ODD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    loaded |-> oddFlag != hitCount[3]); // R6
  AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    byteSpan <= SPAN_W'(5)); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> fullOffset == $past(offsetIn)); // R8
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(widthM1) && $stable(lowOffset) && $stable(shiftLow) &&
                 $stable(hitCount) && $stable(oddFlag) && $stable(byteSpan) &&
                 $stable(fullOffset)); // R9
endmodule

bind bfp_decoder bfp_decoder_chk #(.OFF_W(OFF_W), .LOG2W(LOG2W), .MODE_W(MODE_W),
  .SPAN_W(SPAN_W)) u_chk (.*);

// File: tb/sim_bfp_decoder.sv
`timescale 1ns/1ps
module sim_bfp_decoder;
  typedef struct packed {
    logic [4:0]  w;
    logic [4:0]  lo;
    logic [4:0]  sh;
    logic [5:0]  hit;
    logic        odd;
    logic [2:0]  span;
    logic [31:0] off;
  } exp_t;

  logic clk = 1'b0, rstN = 1'b0, loadStb = 1'b0, extWidthSel = 1'b0;
  logic [4:0] extWidthImm = '0, regWidthVal = '0;
  logic [1:0] targetMode = '0;
  logic [31:0] offsetIn = '0;
  logic [4:0] widthM1, lowOffset, shiftLow;
  logic [5:0] hitCount;
  logic oddFlag;
  logic [2:0] byteSpan;
  logic [31:0] fullOffset;

  int checks = 0, fails = 0;
  exp_t q[$];
  exp_t lastExp;

  bfp_decoder u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input bit sel, input int regW, input int imm,
                                 input int mode, input logic [31:0] off);
    exp_t e;
    int w, lo, hit;
    bit mem;
    mem = (mode != 0);
    w = ((sel ? regW : imm) + 31) % 32;
    lo = int'(off[4:0]);
    if (mem) lo = lo % 8;
    hit = w + lo;
    e.w = 5'(w); e.lo = 5'(lo); e.hit = 6'(hit);
    e.sh = mem ? 5'(7 - (hit % 8)) : 5'(31 - (hit % 32));
    e.odd = ((hit / 8) % 2) == 0;
    e.span = mem ? 3'(hit / 8 + 1) : 3'd0;
    e.off = off;
    return e;
  endfunction

  task automatic compareAll(input exp_t e, input string ctx);
    chk(widthM1 == e.w,      {ctx, " R1 widthM1"},    32'(widthM1), 32'(e.w));
    chk(lowOffset == e.lo,   {ctx, " R2/R5 lowOffset"}, 32'(lowOffset), 32'(e.lo));
    chk(hitCount == e.hit,   {ctx, " R3 hitCount"},   32'(hitCount), 32'(e.hit));
    chk(shiftLow == e.sh,    {ctx, " R4/R5 shiftLow"}, 32'(shiftLow), 32'(e.sh));
    chk(oddFlag == e.odd,    {ctx, " R6 oddFlag"},    32'(oddFlag), 32'(e.odd));
    chk(byteSpan == e.span,  {ctx, " R7 byteSpan"},   32'(byteSpan), 32'(e.span));
    chk(fullOffset == e.off, {ctx, " R8 fullOffset"}, fullOffset, e.off);
  endtask

  task automatic drive(input bit sel, input int regW, input int imm,
                       input int mode, input logic [31:0] off);
    @(negedge clk);
    extWidthSel = sel; regWidthVal = 5'(regW); extWidthImm = 5'(imm);
    targetMode = 2'(mode); offsetIn = off; loadStb = 1'b1;
    lastExp = model(sel, regW, imm, mode, off);
    q.push_back(lastExp);
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // monitor: after each capturing edge, compare at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (loadStb && rstN) begin
        @(negedge clk);
        if (q.size() == 0) chk(1'b0, "R3 scoreboard underflow", 0, 1);
        else compareAll(q.pop_front(), "load");
      end
    end
  end

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog R9", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10: outputs cleared during reset
    chk({widthM1, lowOffset, shiftLow, hitCount, oddFlag, byteSpan, fullOffset} == '0,
        "R10 reset state", 32'(hitCount), 0);
    @(negedge clk);
    rstN = 1'b1;

    drive(0, 0, 0, 0, 32'h0);          // width 32 immediate, R1
    drive(0, 0, 1, 0, 32'h0);          // width 1
    drive(1, 8, 3, 0, 32'h5);          // register width, R1
    drive(1, 0, 7, 0, 32'h1F);         // width 32 from register, largest hit count
    drive(0, 0, 0, 1, 32'h1F);         // memory R5, five bytes R7
    drive(0, 0, 1, 2, 32'h0);          // memory one byte
    drive(0, 0, 9, 3, 32'h12345678);   // memory two bytes
    drive(0, 0, 5, 1, 32'hFFFFFFF3);   // memory boundary hit 7
    drive(1, 17, 0, 2, 32'h0000000C);  // memory, offset bits 4:3 dropped
    for (int i = 0; i < 12; i++) begin
      drive(bit'(i % 2), (i * 7 + 3) % 32, (i * 11 + 1) % 32, i % 4,
            32'h9E3779B9 * (i + 1));
    end

    // R9: inputs change without strobe; outputs must hold
    @(negedge clk);
    extWidthSel = ~extWidthSel; extWidthImm = 5'd13; regWidthVal = 5'd22;
    targetMode = 2'd0; offsetIn = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    compareAll(lastExp, "R9 hold");
    targetMode = 2'd2; offsetIn = 32'h00000007;
    repeat (2) @(negedge clk);
    compareAll(lastExp, "R9 hold2");

    // R10: reset in the middle of operation clears outputs
    rstN = 1'b0;
    @(negedge clk);
    chk({widthM1, lowOffset, shiftLow, hitCount, oddFlag, byteSpan, fullOffset} == '0,
        "R10 reset mid-run", fullOffset, 0);
    rstN = 1'b1;
    drive(0, 0, 2, 0, 32'h3);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 scoreboard drained", 32'(q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule